// File: doc/BRIEF.md
# Clock Setting Cache Access Controller

This block keeps a bit-addressable store of clock-generator settings. A host reads or writes one setting at a time. The host names a setting with a counter-type code and a counter-parameter code, then raises a one-cycle read or write strobe. The controller moves the selected field between the store and the data buses one bit per clock, from the least significant bit upward. While it does this it holds `busy` high.

The field width depends on the code pair. Each supported counter type owns a 20-bit slot, which holds two 9-bit counts and two single-bit flags. A read result appears on `rdata` once `busy` falls. A write takes its value from `wdata` at the clock edge that accepts the strobe. Code pairs that are not supported complete in one busy cycle and touch nothing.

Top module: `pcache_rw_ctrl`

## Requirements
- R1: Strobes are sampled on the rising clock edge. An access starts when a strobe is high at an edge, `busy` is low and neither strobe was high at the previous edge, so a strobe held high starts one access.
- R2: `busy` is low in the cycle in which the strobe is presented and is high from the next rising edge.
- R3: `busy` stays high for exactly W cycles, where W is the width of the selected field, and for one cycle when the code pair is not supported.
- R4: After a read, `rdata` holds the field in bits W-1:0 and zeros above. It stays stable until the next read is accepted. Writes leave `rdata` unchanged.
- R5: A write stores `wdata[W-1:0]`, sampled at the accepting edge. `wdata` bits at or above W, and every value on `wdata` while `busy` is high, have no effect.
- R6: Field map for counter type t (0 to NUM_TYPES-1, default 5 types). Param code 0 is 9 bits at offset 20t. Param code 1 is 9 bits at 20t+9. Param code 2 is 1 bit at 20t+18. Param code 3 is 1 bit at 20t+19. Every other type or param code is unsupported.
- R7: A strobe that arrives while `busy` is high is ignored. The type and param codes are captured at the accepting edge, so later changes do not affect the access in progress.
- R8: An unsupported read returns `rdata` = 0, and an unsupported write leaves the store unchanged.
- R9: If both strobes are high at an accepting edge, the access is a write.
- R10: After reset, `busy` and `rdata` are zero and every stored bit is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_stb | input | 1 | Read request strobe |
| wr_stb | input | 1 | Write request strobe |
| ctype | input | 3 | Counter-type code |
| cparam | input | 3 | Counter-parameter code |
| wdata | input | 9 | Write value |
| rdata | output | 9 | Read result, valid while busy is low |
| busy | output | 1 | Access in progress |

## Verification
The assertions assume that the host takes a strobe back down before it starts another access. They also assume that `rdata` matters only while `busy` is low. The driver waits for `busy` to fall, pulses one strobe for a single cycle, and scrambles `wdata`, `ctype` and `cparam` during every busy period. Deliberate breaches of these rules are kept to separate steps, each with a known expected outcome: a held strobe, a strobe during busy, and both strobes at once.

// File: rtl/pcache_rw_ctrl.sv
module pcache_rw_ctrl #(
  parameter int TYPE_W    = 3,
  parameter int PARAM_W   = 3,
  parameter int CNT_W     = 9,
  parameter int NUM_TYPES = 5,
  parameter int DATA_W    = CNT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_stb,
  input  logic               wr_stb,
  input  logic [TYPE_W-1:0]  ctype,
  input  logic [PARAM_W-1:0] cparam,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic               busy
);
  localparam int SLOT_BITS  = 2 * CNT_W + 2;
  localparam int CACHE_BITS = NUM_TYPES * SLOT_BITS;
  localparam int OFF_W      = $clog2(CACHE_BITS);
  localparam int IDX_W      = $clog2(DATA_W + 1);

  logic [CACHE_BITS-1:0] cache;
  logic                  prev_stb, is_wr;
  logic [OFF_W-1:0]      base, lk_off;
  logic [IDX_W-1:0]      len, idx, lk_len;
  logic [DATA_W-1:0]     wbuf;
  logic [TYPE_W-1:0]     sel_type;

  always_comb begin
    lk_off = '0;
    lk_len = '0;
    if (int'(ctype) < NUM_TYPES) begin
      case (int'(cparam))
        0: begin lk_off = OFF_W'(int'(ctype) * SLOT_BITS);             lk_len = IDX_W'(CNT_W); end
        1: begin lk_off = OFF_W'(int'(ctype) * SLOT_BITS + CNT_W);     lk_len = IDX_W'(CNT_W); end
        2: begin lk_off = OFF_W'(int'(ctype) * SLOT_BITS + 2 * CNT_W); lk_len = IDX_W'(1); end
        3: begin lk_off = OFF_W'(int'(ctype) * SLOT_BITS + 2 * CNT_W + 1); lk_len = IDX_W'(1); end
        default: ;
      endcase
    end
  end

  wire              any_stb = rd_stb | wr_stb;
  wire              start   = any_stb & ~busy & ~prev_stb;
  wire [OFF_W-1:0]  pos     = base + OFF_W'(idx);
  wire              moving  = busy & (idx < len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cache    <= '0;
      prev_stb <= 1'b0;
      busy     <= 1'b0;
      is_wr    <= 1'b0;
      base     <= '0;
      len      <= '0;
      idx      <= '0;
      wbuf     <= '0;
      rdata    <= '0;
      sel_type <= '0;
    end else begin
      prev_stb <= any_stb;
      if (start) begin
        busy     <= 1'b1;
        is_wr    <= wr_stb;
        base     <= lk_off;
        len      <= lk_len;
        idx      <= '0;
        wbuf     <= wdata;
        sel_type <= ctype;
        if (!wr_stb) rdata <= '0;
      end else if (busy) begin
        if (moving) begin
          if (is_wr) cache[pos]  <= wbuf[idx];
          else       rdata[idx]  <= cache[pos];
        end
        if (idx + 1'b1 >= len) busy <= 1'b0;
        idx <= idx + 1'b1;
      end
    end
  end

  AST_BUSY_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(any_stb)); // R2
  AST_BUSY_NOT_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx <= len)); // R3
  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(rdata)); // R4
  AST_READ_KEEPS_CACHE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !is_wr) |=> $stable(cache)); // R8
  AST_SELECT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && any_stb) |=> $stable(sel_type) && $stable(base)); // R7
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && wr_stb) |=> is_wr); // R9
endmodule

// File: tb/sim_pcache_rw_ctrl.sv
`timescale 1ns/1ps
module sim_pcache_rw_ctrl;
  logic clk = 0, rst_n = 0, rd_stb = 0, wr_stb = 0;
  logic [2:0] ctype = 0, cparam = 0;
  logic [8:0] wdata = 0;
  logic [8:0] rdata;
  logic busy;
  int checks = 0, fails = 0, bcnt = 0;
  logic [99:0] mc = '0;
  logic [8:0] last_rd = 0;
  logic [8:0] exp_d[$];
  int exp_l[$];

  pcache_rw_ctrl u0 (.clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .ctype(ctype), .cparam(cparam), .wdata(wdata), .rdata(rdata), .busy(busy));

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  function automatic int wid(input int t, input int p);
    if (t > 4 || p > 3) return 0;
    return (p < 2) ? 9 : 1;
  endfunction
  function automatic int off(input int t, input int p);
    return t * 20 + ((p == 0) ? 0 : (p == 1) ? 9 : (p == 2) ? 18 : 19);
  endfunction

  // monitor: pop expected result when busy falls
  always @(negedge clk) if (rst_n) begin
    if (busy) bcnt++;
    else if (bcnt > 0) begin
      if (exp_d.size() == 0) chk(0, "R1 unexpected access", bcnt, 0);
      else begin
        logic [8:0] ed; int el;
        ed = exp_d.pop_front(); el = exp_l.pop_front();
        chk(rdata == ed, "R4/R5/R6 rdata", rdata, ed);
        chk(bcnt == el, "R3 busy length", bcnt, el);
      end
      bcnt = 0;
    end
  end

  task automatic wait_idle();
    do @(negedge clk); while (busy);
    @(negedge clk);
  endtask

  task automatic model(input bit rd, input bit wr, input int t, input int p, input logic [8:0] d);
    int w = wid(t, p);
    if (wr) begin
      for (int i = 0; i < w; i++) mc[off(t, p) + i] = d[i];
    end else if (rd) begin
      last_rd = '0;
      for (int i = 0; i < w; i++) last_rd[i] = mc[off(t, p) + i];
    end
    exp_d.push_back(last_rd);
    exp_l.push_back(w == 0 ? 1 : w);
  endtask

  task automatic access(input bit rd, input bit wr, input int t, input int p, input logic [8:0] d);
    wait_idle();
    rd_stb = rd; wr_stb = wr; ctype = 3'(t); cparam = 3'(p); wdata = d;
    chk(busy == 0, "R2 busy low with strobe", busy, 0);
    model(rd, wr, t, p, d);
    @(negedge clk);
    rd_stb = 0; wr_stb = 0;
    chk(busy == 1, "R2 busy high after edge", busy, 1);
    wdata = ~d; ctype = 3'(t + 1); cparam = 3'(p ^ 1);   // R5 R7 scramble during busy
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0, "R10 busy after reset", busy, 0);
    chk(rdata == 0, "R10 rdata after reset", rdata, 0);
    for (int p = 0; p < 4; p++) access(1, 0, 2, p, 0);           // R10 store zero
    for (int t = 0; t < 5; t++)
      for (int p = 0; p < 4; p++) access(0, 1, t, p, 9'((t * 97 + p * 61 + 45) ^ 9'h1A5)); // R6
    for (int t = 0; t < 5; t++)
      for (int p = 0; p < 4; p++) access(1, 0, t, p, 0);
    access(1, 0, 6, 0, 0);                // R8 unsupported type
    access(1, 0, 1, 5, 0);                // R8 unsupported param
    access(0, 1, 7, 2, 9'h1FF);           // R8 unsupported write
    access(0, 1, 3, 2, 9'h1FE);           // R5 high bits ignored
    access(1, 0, 3, 2, 0);
    access(1, 0, 3, 3, 0);
    access(1, 1, 4, 1, 9'h0C3);           // R9 write wins
    access(1, 0, 4, 1, 0);
    // R1 held strobe: one access only
    wait_idle();
    rd_stb = 1; ctype = 0; cparam = 1;
    model(1, 0, 0, 1, 0);
    repeat (14) @(negedge clk);
    rd_stb = 0;
    chk(busy == 0, "R1 held strobe no restart", busy, 0);
    // R7 strobe during busy ignored
    access(0, 1, 1, 0, 9'h155);
    @(negedge clk);
    wr_stb = 1; rd_stb = 1; ctype = 1; cparam = 1; wdata = 9'h0AA;
    @(negedge clk);
    wr_stb = 0; rd_stb = 0;
    access(1, 0, 1, 1, 0);
    access(1, 0, 1, 0, 0);
    wait_idle();
    repeat (3) @(negedge clk);
    chk(exp_d.size() == 0, "R1 all accesses completed", exp_d.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule